// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Engine

This block is the master side of a two-wire serial bus (I2C style). It runs complete write and read transfers to a slave with a 7-bit address. Writing a byte into the holding register while the engine is idle starts a transfer. The engine then sends a START condition, an address byte whose last bit gives the direction, and a series of data bytes. Each byte is followed by an acknowledge slot. The transfer continues as long as the holding register has been refilled by the time each byte is acknowledged. Once that register is found empty, the engine closes the transfer with STOP on its own; there is no stop command. Both bus lines are open-drain: each output is an enable that pulls its line low. The SCL low and high phase lengths come from two divider inputs and are counted in system clocks.

The controller is a single state machine with these states:

- `ST_IDLE`: both lines released.
- `ST_START`: SDA pulled while SCL is high.
- `ST_BIT_LO`: SCL low. SDA takes the next bit.
- `ST_BIT_HI`: SCL high. SDA is sampled at the end of this phase.
- `ST_STOP_LO`: SCL and SDA both pulled.
- `ST_STOP_HI`: SCL released, SDA still pulled.
- `ST_STOP_REL`: SDA released, which forms STOP.

The transitions are:

- idle-to-start: a holding write while idle.
- start-to-low, low-to-high: phase timeout.
- high-to-low: the next bit, or the next byte after an acknowledge.
- high-to-stop: NACK, or an empty holding register at the acknowledge slot.
- stop-low-to-stop-high, stop-high-to-release: phase timeout.
- release-to-idle: phase timeout. This sets the complete flag.

Three status flags (ready, not-acknowledge, complete) feed a masked interrupt.

Top module: `twb_master`

## Requirements
- R1: After reset, both pull enables are 0, ready=1, complete=1 and not-acknowledge=0.
- R2: START is SDA falling while SCL is released, and STOP is SDA rising while SCL is released. At every other time, SDA changes only while SCL is pulled low.
- R3: The first byte of a transfer is the 7-bit device address, MSB first, followed by the direction bit. The direction bit is 1 when `rd_sel` is 1 (read) and 0 for a write.
- R4: Every byte is 8 bits, MSB first, and is followed by a ninth slot. When the master sent the byte, it releases SDA in that slot.
- R5: Every SCL low phase lasts max(`scl_lo_len`,1) clocks. Every SCL high phase after START lasts max(`scl_hi_len`,1) clocks.
- R6: In write mode, each acknowledge moves the waiting holding byte into the shifter and sets ready. A holding write clears ready. The number of bytes in a transfer is unbounded.
- R7: If the holding register is empty when a byte's acknowledge slot ends, the master sends STOP and then sets complete. A holding write clears complete.
- R8: If SDA is high in the acknowledge slot of a byte the master sent, the master sets not-acknowledge and goes straight to STOP. Any waiting holding byte is discarded, and ready and complete are set.
- R9: A pulse on `stat_rd` clears not-acknowledge.
- R10: In read mode, after the address is acknowledged, the master releases SDA for 8 bits and collects them MSB first into `rx_data`. In the ninth slot it pulls SDA low if the holding register was written again, and then continues. Otherwise it leaves SDA high and sends STOP.
- R11: `irq` is the OR of the enabled flags. `irq_en` bit 0 enables ready, bit 1 enables not-acknowledge and bit 2 enables complete.
- R12: Holding writes made during a transfer never cause another START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Holding register data |
| dev_addr | input | 7 | Slave address |
| rd_sel | input | 1 | Direction select, 1 = read |
| scl_lo_len | input | DIV_W | SCL low phase length in clocks |
| scl_hi_len | input | DIV_W | SCL high phase length in clocks |
| stat_rd | input | 1 | Status read strobe, clears not-acknowledge |
| irq_en | input | 3 | Interrupt enable mask |
| sda_in | input | 1 | Sensed SDA line level |
| sda_pull | output | 1 | Pull SDA low |
| scl_pull | output | 1 | Pull SCL low |
| rx_data | output | 8 | Last byte received |
| st_txrdy | output | 1 | Ready flag: holding register empty |
| st_nack | output | 1 | Not-acknowledge flag |
| st_txcomp | output | 1 | Complete flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check on every cycle that SDA moves only while SCL is low (except for the START and STOP edges) and that both lines are released in idle. They also check that the bit counter stays in range, that the master releases SDA in the acknowledge slot of its own bytes, and that not-acknowledge leads straight into STOP. They also check that complete is only seen in idle and that a holding write clears ready. Only the bench scenarios can show the rest. These are the address and direction byte, the data bytes as the slave receives them, the read bytes assembled into `rx_data`, and the master's acknowledge pattern in read mode. They also cover the measured SCL phase lengths and the single START and STOP per transfer. The bench sweeps direction, byte count and divider settings, and separately covers the discard of waiting data after a NACK.

// File: rtl/twb_pkg.sv
package twb_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 7;
    localparam int unsigned ACK_SLOT = 8;
    localparam int unsigned CNT_W    = 4;
    localparam int unsigned FLG_RDY  = 0;
    localparam int unsigned FLG_NACK = 1;
    localparam int unsigned FLG_DONE = 2;
    localparam int unsigned FLG_N    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_STOP_REL
    } twb_state_t;
endpackage

// File: rtl/twb_timer.sv
module twb_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] len,
    output logic             expire
);
    localparam int unsigned EXT_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    // A phase ends when cnt+1 reaches len, so a length of 0 behaves as 1.
    assign expire = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, len};

    // R5: the phase counter never wraps before its phase ends
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '1);
endmodule

// File: rtl/twb_flags.sv
module twb_flags
    import twb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic             set_rdy,
    input  logic             set_nack,
    input  logic             set_done,
    input  logic [FLG_N-1:0] en,
    output logic [FLG_N-1:0] flags,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= FLG_N'((1 << FLG_RDY) | (1 << FLG_DONE));
        end else begin
            if (wr)           flags[FLG_RDY]  <= 1'b0;
            else if (set_rdy) flags[FLG_RDY]  <= 1'b1;
            if (set_nack)     flags[FLG_NACK] <= 1'b1;
            else if (rd)      flags[FLG_NACK] <= 1'b0;
            if (set_done)     flags[FLG_DONE] <= 1'b1;
            else if (wr)      flags[FLG_DONE] <= 1'b0;
        end
    end

    assign irq = |(flags & en);

    // R6: a holding write always leaves ready clear on the next cycle
    p_wr_clears_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !flags[FLG_RDY]);
    // R9: a status read without a new NACK leaves the flag clear
    p_rd_clears_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_nack) |=> !flags[FLG_NACK]);
endmodule

// File: rtl/twb_master.sv
module twb_master
    import twb_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_wr,
    input  logic [BYTE_W-1:0] hold_wdata,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              rd_sel,
    input  logic [DIV_W-1:0]  scl_lo_len,
    input  logic [DIV_W-1:0]  scl_hi_len,
    input  logic              stat_rd,
    input  logic [FLG_N-1:0]  irq_en,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              st_txrdy,
    output logic              st_nack,
    output logic              st_txcomp,
    output logic              irq
);
    twb_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] sh_q, hold_q;
    logic              hold_full_q, is_addr_q, rd_q, rx_ack_q;
    logic              expire, tmr_clr, lo_phase;
    logic              master_tx, ack_end, nack_ev, go_on, done_ev, bit_drive;
    logic [FLG_N-1:0]  flags;

    assign lo_phase  = (state_q == ST_BIT_LO) || (state_q == ST_STOP_LO);
    assign tmr_clr   = (state_q == ST_IDLE) || expire;
    assign master_tx = is_addr_q || !rd_q;
    assign ack_end   = (state_q == ST_BIT_HI) && expire && (bitcnt_q == CNT_W'(ACK_SLOT));
    assign nack_ev   = ack_end && master_tx && sda_in;
    assign go_on     = ack_end && !nack_ev &&
                       (master_tx ? ((is_addr_q && rd_q) || hold_full_q) : rx_ack_q);
    assign done_ev   = (state_q == ST_STOP_REL) && expire;

    twb_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .len    (lo_phase ? scl_lo_len : scl_hi_len),
        .expire (expire)
    );

    twb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (hold_wr),
        .rd       (stat_rd),
        .set_rdy  (go_on || nack_ev || done_ev),
        .set_nack (nack_ev),
        .set_done (done_ev),
        .en       (irq_en),
        .flags    (flags),
        .irq      (irq)
    );

    assign st_txrdy  = flags[FLG_RDY];
    assign st_nack   = flags[FLG_NACK];
    assign st_txcomp = flags[FLG_DONE];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (hold_wr) state_d = ST_START;
            ST_START:    if (expire) state_d = ST_BIT_LO;
            ST_BIT_LO:   if (expire) state_d = ST_BIT_HI;
            ST_BIT_HI: begin
                if (expire) begin
                    if (bitcnt_q != CNT_W'(ACK_SLOT)) state_d = ST_BIT_LO;
                    else if (go_on)                   state_d = ST_BIT_LO;
                    else                              state_d = ST_STOP_LO;
                end
            end
            ST_STOP_LO:  if (expire) state_d = ST_STOP_HI;
            ST_STOP_HI:  if (expire) state_d = ST_STOP_REL;
            ST_STOP_REL: if (expire) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bitcnt_q    <= '0;
            sh_q        <= '0;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            is_addr_q   <= 1'b0;
            rd_q        <= 1'b0;
            rx_ack_q    <= 1'b0;
            rx_data     <= '0;
        end else begin
            state_q <= state_d;
            if (hold_wr) begin
                hold_q      <= hold_wdata;
                hold_full_q <= 1'b1;
            end
            if (state_q == ST_IDLE && hold_wr) begin
                sh_q      <= {dev_addr, rd_sel};
                rd_q      <= rd_sel;
                is_addr_q <= 1'b1;
                bitcnt_q  <= '0;
            end
            if (state_q == ST_BIT_HI && expire) begin
                if (bitcnt_q != CNT_W'(ACK_SLOT)) begin
                    sh_q     <= {sh_q[BYTE_W-2:0], sda_in};
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == CNT_W'(BYTE_W - 1)) begin
                        rx_ack_q <= hold_full_q;
                        if (!master_tx) rx_data <= {sh_q[BYTE_W-2:0], sda_in};
                    end
                end else begin
                    bitcnt_q  <= '0;
                    is_addr_q <= 1'b0;
                    if (go_on) begin
                        sh_q <= hold_q;
                        if (!hold_wr) hold_full_q <= 1'b0;
                    end
                end
            end
            if ((nack_ev || done_ev) && !hold_wr) hold_full_q <= 1'b0;
            if (done_ev && hold_wr) hold_full_q <= 1'b0;
        end
    end

    // Line drive per state
    always_comb begin
        if (bitcnt_q != CNT_W'(ACK_SLOT)) bit_drive = master_tx && !sh_q[BYTE_W-1];
        else                              bit_drive = !master_tx && rx_ack_q;
        sda_pull = 1'b0;
        scl_pull = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin sda_pull = 1'b0;      scl_pull = 1'b0; end
            ST_START:    begin sda_pull = 1'b1;      scl_pull = 1'b0; end
            ST_BIT_LO:   begin sda_pull = bit_drive; scl_pull = 1'b1; end
            ST_BIT_HI:   begin sda_pull = bit_drive; scl_pull = 1'b0; end
            ST_STOP_LO:  begin sda_pull = 1'b1;      scl_pull = 1'b1; end
            ST_STOP_HI:  begin sda_pull = 1'b1;      scl_pull = 1'b0; end
            ST_STOP_REL: begin sda_pull = 1'b0;      scl_pull = 1'b0; end
            default:     begin sda_pull = 1'b0;      scl_pull = 1'b0; end
        endcase
    end

    // R1: idle keeps both lines released
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sda_pull && !scl_pull));
    // R2: with SCL released, SDA moves only to form START or STOP
    p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull))) |->
        ((state_q == ST_START && sda_pull) || (state_q == ST_STOP_REL && !sda_pull)));
    // R4: bit counter never passes the acknowledge slot
    p_bitcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= CNT_W'(ACK_SLOT));
    // R4: master releases SDA in the acknowledge slot of its own bytes
    p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BIT_LO || state_q == ST_BIT_HI) &&
         bitcnt_q == CNT_W'(ACK_SLOT) && master_tx) |-> !sda_pull);
    // R7: complete is only ever seen with the engine idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_txcomp |-> (state_q == ST_IDLE));
    // R8: a new NACK leads straight into the stop sequence
    p_nack_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_nack) |-> (state_q == ST_STOP_LO));
    // R12: START is only entered from idle
    p_start_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: tb/twb_master_tb.sv
module twb_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;
    localparam int NO_NACK = 99;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_wr = 1'b0;
    logic [7:0] hold_wdata = '0;
    logic [6:0] dev_addr = '0;
    logic rd_sel = 1'b0;
    logic [DIV_W-1:0] scl_lo_len = 8'd2;
    logic [DIV_W-1:0] scl_hi_len = 8'd2;
    logic stat_rd = 1'b0;
    logic [2:0] irq_en = '0;
    logic sda_in, sda_pull, scl_pull, st_txrdy, st_nack, st_txcomp, irq;
    logic [7:0] rx_data;
    logic slv_pull = 1'b0;

    int n_checks = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_in = ~(sda_pull | slv_pull);

    twb_master #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_wr(hold_wr), .hold_wdata(hold_wdata),
        .dev_addr(dev_addr), .rd_sel(rd_sel), .scl_lo_len(scl_lo_len),
        .scl_hi_len(scl_hi_len), .stat_rd(stat_rd), .irq_en(irq_en),
        .sda_in(sda_in), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .rx_data(rx_data), .st_txrdy(st_txrdy), .st_nack(st_nack),
        .st_txcomp(st_txcomp), .irq(irq)
    );

    function automatic logic [7:0] rbyte(input int i);
        return 8'(((i * 29) ^ 195) & 255);
    endfunction

    function automatic logic [7:0] dbyte(input int k, input int s);
        return 8'((k * 53 + s * 11 + 31) & 255);
    endfunction

    // Slave model
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int bitc = 0, bidx = 0, nstart = 0, nstop = 0;
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    int nack_idx = NO_NACK;
    logic in_ack = 1'b0, rd_mode = 1'b0, ok_cont;
    logic [7:0] shreg = '0, rb;
    logic [7:0] blog [0:7];
    logic mack [0:7];

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_scl && !scl_pull) begin
                if (prev_sda && !sda_in) begin
                    nstart++; bitc = 0; bidx = 0; in_ack = 1'b0; rd_mode = 1'b0; slv_pull = 1'b0;
                end
                if (!prev_sda && sda_in) nstop++;
            end
            if (prev_scl && scl_pull) begin
                last_hi = hi_run; hi_run = 0;
                if (!in_ack && bitc == 8) begin
                    in_ack = 1'b1;
                    if (bidx < 8) blog[bidx] = shreg;
                    if (bidx == 0 || !rd_mode) slv_pull = (bidx != nack_idx);
                    else slv_pull = 1'b0;
                end else if (in_ack) begin
                    ok_cont = (bidx == 0) ? (nack_idx != 0) : mack[bidx];
                    in_ack = 1'b0; bitc = 0; bidx++;
                    if (rd_mode && ok_cont) begin
                        rb = rbyte(bidx); slv_pull = !rb[7];
                    end else slv_pull = 1'b0;
                end else if (rd_mode && bidx >= 1 && bitc >= 1 && bitc < 8) begin
                    rb = rbyte(bidx); slv_pull = !rb[7-bitc];
                end
            end
            if (!prev_scl && !scl_pull) begin
                last_lo = lo_run; lo_run = 0;
                if (in_ack) begin
                    if (rd_mode && bidx >= 1 && bidx < 8) mack[bidx] = !sda_in;
                end else if (bitc < 8) begin
                    shreg = {shreg[6:0], sda_in}; bitc++;
                    if (bitc == 8 && bidx == 0) rd_mode = shreg[0];
                end
            end
            if (!scl_pull) hi_run++; else lo_run++;
            prev_scl = !scl_pull;
            prev_sda = ~(sda_pull | slv_pull);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_hold(input logic [7:0] d);
        hold_wdata = d; hold_wr = 1'b1; tick(); hold_wr = 1'b0;
    endtask

    task automatic run_xfer(input bit rd, input int n, input int lo, input int hi,
                            input int nk, input int s);
        int st0, sp0, t, exp_b, lo_e, hi_e;
        logic [6:0] a;
        a = 7'(((s * 19) + 5) & 127);
        dev_addr = a; rd_sel = rd; scl_lo_len = 8'(lo); scl_hi_len = 8'(hi); nack_idx = nk;
        st0 = nstart; sp0 = nstop;
        tick();
        wr_hold(dbyte(0, s));
        chk(!st_txcomp, "R7 complete cleared by write", int'(st_txcomp), 0);
        for (int k = 1; k < n; k++) begin
            t = 0;
            while (!(st_txrdy || st_txcomp) && t < 20000) begin tick(); t++; end
            if (st_txcomp) break;
            wr_hold(dbyte(k, s));
        end
        t = 0;
        while (!st_txcomp && t < 20000) begin tick(); t++; end
        chk(t < 20000, "R7 transfer completes", t, 0);
        chk(nstart - st0 == 1, "R12 one START per transfer", nstart - st0, 1);
        chk(nstop - sp0 == 1, "R2 one STOP per transfer", nstop - sp0, 1);
        chk(blog[0] == {a, rd}, "R3 address and direction byte", int'(blog[0]), int'({a, rd}));
        lo_e = (lo == 0) ? 1 : lo; hi_e = (hi == 0) ? 1 : hi;
        chk(last_lo == lo_e, "R5 SCL low phase", last_lo, lo_e);
        chk(last_hi == hi_e, "R5 SCL high phase", last_hi, hi_e);
        chk(st_txrdy, "R6 ready after transfer", int'(st_txrdy), 1);
        exp_b = (nk == NO_NACK) ? n + 1 : nk + 1;
        chk(bidx == exp_b, "R7 bytes on bus", bidx, exp_b);
        chk(st_nack == (nk != NO_NACK), "R8 nack flag", int'(st_nack), int'(nk != NO_NACK));
        if (nk == NO_NACK) begin
            if (!rd) begin
                for (int i = 1; i <= n; i++)
                    chk(blog[i] == dbyte(i - 1, s), "R4 R6 data byte at slave",
                        int'(blog[i]), int'(dbyte(i - 1, s)));
            end else begin
                chk(rx_data == rbyte(n), "R10 last byte read", int'(rx_data), int'(rbyte(n)));
                for (int i = 1; i <= n; i++)
                    chk(mack[i] == (i < n), "R10 master acknowledge pattern",
                        int'(mack[i]), int'(i < n));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin blog[i] = '0; mack[i] = 1'b0; end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(!sda_pull && !scl_pull, "R1 lines released", int'({sda_pull, scl_pull}), 0);
        chk(st_txrdy && st_txcomp && !st_nack, "R1 flags at reset",
            int'({st_txcomp, st_nack, st_txrdy}), 5);
        irq_en = 3'b100; tick();
        chk(irq, "R11 complete enabled", int'(irq), 1);
        irq_en = 3'b010; tick();
        chk(!irq, "R11 nack enabled while clear", int'(irq), 0);

        for (int rd = 0; rd < 2; rd++)
            for (int n = 1; n <= 3; n++)
                for (int c = 0; c < 3; c++) begin
                    int lo, hi;
                    lo = (c == 0) ? 1 : (c == 1) ? 2 : 4;
                    hi = (c == 0) ? 1 : (c == 1) ? 3 : 0;
                    run_xfer(rd[0], n, lo, hi, NO_NACK, rd * 9 + n * 3 + c);
                end

        // Long write transfer
        run_xfer(1'b0, 6, 2, 2, NO_NACK, 41);

        // NACK on a data byte while another byte waits
        run_xfer(1'b0, 3, 2, 1, 1, 50);
        chk(irq, "R11 nack interrupt", int'(irq), 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
        chk(!st_nack, "R9 status read clears nack", int'(st_nack), 1'b0);
        run_xfer(1'b0, 1, 2, 2, NO_NACK, 51);
        chk(blog[1] == dbyte(0, 51), "R8 waiting byte discarded",
            int'(blog[1]), int'(dbyte(0, 51)));

        // NACK on the address byte, in both directions
        run_xfer(1'b0, 2, 1, 2, 0, 60);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        run_xfer(1'b1, 2, 3, 1, 0, 61);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
        chk(!st_nack && !irq, "R9 R11 nack cleared", int'({st_nack, irq}), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule